// File: doc/BRIEF.md
# Video Timing Slave Capture Window

This block sits on the pixel input side of a video encoder that runs as a timing slave. It receives horizontal sync, vertical sync, a field strobe and a blanking strobe from an upstream source, each with its own active level chosen by a polarity bit. All four are registered, flipped to active-high, and then watched for edges.

The leading edge of horizontal sync restarts a horizontal pixel counter at zero. A capture enable rises at a programmable start count and stays high for a programmable number of pixels (720 unless another length is given). That enable tells the downstream pixel path when to take active data. A half-line counter advances twice per line. On a selected edge of vertical sync, either its leading or its trailing edge, the half-line counter is cleared and the current field is decided. The field comes either from where that edge falls within the line or from the external field strobe. Field decisions and half-line clears take effect only while the syncs are configured as inputs. Configuration arrives as static parallel inputs. For a 525-line source, vertical sync edges arrive at 59.94 fields per second.

Top module: `vid_slave_window`

## Requirements
- R1: Each of the four strobes (bit 0 horizontal sync, bit 1 vertical sync, bit 2 field, bit 3 blank of `cfg_pol_i`) is treated as active when its pin level differs from its polarity bit, so a polarity bit of 1 means active-low.
- R2: After the horizontal sync pin becomes active ahead of clock edge k, `hcount_o` reads 0 after edge k+1 and then rises by one per clock. It saturates at its all-ones value and holds 0 from reset until the first horizontal sync.
- R3: `cap_en_o` is high exactly while start <= `hcount_o` < start + length, where start is `cfg_start_i` and length is the effective window length.
- R4: A `cfg_len_i` of zero selects the default window length given by parameter ACT_DEF (720 by default).
- R5: When `cfg_blank_gate_i` is 1, `cap_en_o` is low in every cycle that follows a cycle in which the blank strobe was active. When the gate bit is 0, the blank strobe has no effect on the enable.
- R6: `halfline_o` increments by one on each horizontal sync leading edge and once when `hcount_o` equals `cfg_half_i`.
- R7: `cfg_vs_trail_i` = 0 selects the active-going edge of vertical sync and 1 selects the inactive-going edge. Only the selected edge clears `halfline_o` to 0, and the clear overrides any increment in the same cycle.
- R8: On the selected vertical edge, `field_o` takes the external field strobe level when `cfg_field_ext_i` is 1. Otherwise it takes 0 if `hcount_o` is below `cfg_half_i` at that edge and 1 if it is not.
- R9: While `cfg_sync_in_i` is 0, vertical sync edges neither clear `halfline_o` nor change `field_o`.
- R10: After synchronous reset, `hcount_o`, `halfline_o`, `field_o` and `cap_en_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (1x rate) |
| rst_n | input | 1 | Synchronous active-low reset |
| hsync_i | input | 1 | Horizontal sync strobe, raw pin level |
| vsync_i | input | 1 | Vertical sync strobe, raw pin level |
| field_i | input | 1 | External field strobe, raw pin level |
| blank_i | input | 1 | Blanking strobe, raw pin level |
| cfg_pol_i | input | 4 | Polarity per strobe, 1 = active-low |
| cfg_sync_in_i | input | 1 | 1 = syncs are inputs, so vertical edges act |
| cfg_vs_trail_i | input | 1 | 0 = leading, 1 = trailing vertical edge |
| cfg_field_ext_i | input | 1 | 1 = field taken from field strobe |
| cfg_blank_gate_i | input | 1 | 1 = blank strobe suppresses capture |
| cfg_start_i | input | START_W | Capture start count |
| cfg_len_i | input | ACT_W | Capture length, 0 = ACT_DEF |
| cfg_half_i | input | HCNT_W | Horizontal count of the mid-line point |
| cap_en_o | output | 1 | Capture enable for active pixels |
| hcount_o | output | HCNT_W | Horizontal pixel count |
| halfline_o | output | LCNT_W | Half-line count since the last field reset |
| field_o | output | 1 | Current field |

## Verification
The bench builds the block with an 8-bit horizontal counter, an 8-bit length field, an 8-bit half-line counter and a default window of 20 pixels. With a 40-cycle line, every pixel position of a line can be checked against a start and length sweep, including the default length. A single 300-cycle line drives the counter into saturation. All sixteen polarity combinations are swept, each with a reset, so every strobe is proven in both active levels. Vertical edges are placed both before and after the mid-line count, in each edge mode and with the syncs disabled, to cover every field decision.

// File: rtl/vts_pkg.sv
// Package: shared constants and types for the slave timing window.
// Assumes the strobe channel order below is used by every sub-block.
package vts_pkg;
    localparam int NUM_CH = 4;   // number of incoming strobes
    localparam int CH_HS  = 0;   // horizontal sync channel
    localparam int CH_VS  = 1;   // vertical sync channel
    localparam int CH_FLD = 2;   // field strobe channel
    localparam int CH_BLK = 3;   // blanking strobe channel

    // Which transition of a normalised strobe counts as its event.
    typedef enum logic {
        EDGE_LEAD  = 1'b0,
        EDGE_TRAIL = 1'b1
    } edge_kind_e;
endpackage

// File: rtl/pol_sample.sv
// Module: pol_sample
// Registers N raw strobes and flips each to active-high using its polarity
// bit (1 = active-low pin). Assumes the strobes are already synchronous to clk.
module pol_sample #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    input  logic [N-1:0] pol_i,
    output logic [N-1:0] lvl_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_ch
            logic lvl_q;
            // Sample one strobe and remove its polarity.
            always_ff @(posedge clk) begin
                if (!rst_n) lvl_q <= 1'b0;
                else        lvl_q <= raw_i[g] ^ pol_i[g];
            end
            assign lvl_o[g] = lvl_q;
        end
    endgenerate
endmodule

// File: rtl/edge_pick.sv
// Module: edge_pick
// Keeps the previous value of each normalised level and reports, per channel,
// the active-going or inactive-going transition chosen by trail_i.
// Assumes lvl_i comes straight from registers.
module edge_pick
    import vts_pkg::*;
#(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_i,
    input  edge_kind_e   kind_i [N],
    output logic [N-1:0] edge_o
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_ch
            logic prev_q;
            // Remember last sampled level for comparison.
            always_ff @(posedge clk) begin
                if (!rst_n) prev_q <= 1'b0;
                else        prev_q <= lvl_i[g];
            end
            // Pick the transition direction requested for this channel.
            always_comb begin
                if (kind_i[g] == EDGE_TRAIL) edge_o[g] = prev_q & ~lvl_i[g];
                else                         edge_o[g] = lvl_i[g] & ~prev_q;
            end
        end
    endgenerate
endmodule

// File: rtl/line_window.sv
// Module: line_window
// Horizontal pixel counter restarted by the horizontal sync leading edge,
// and the capture enable window derived from it. Assumes HCNT_W >= START_W.
module line_window #(
    parameter int HCNT_W  = 12,
    parameter int START_W = 8,
    parameter int ACT_W   = 11,
    parameter int ACT_DEF = 720
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hs_lead_i,
    input  logic               blank_i,
    input  logic               gate_i,
    input  logic [START_W-1:0] start_i,
    input  logic [ACT_W-1:0]   len_i,
    output logic [HCNT_W-1:0]  hcount_o,
    output logic               run_o,
    output logic               cap_en_o
);
    localparam int SUM_W = ((HCNT_W > ACT_W) ? HCNT_W : ACT_W) + 1;
    localparam logic [HCNT_W-1:0] HMAX = {HCNT_W{1'b1}};
    localparam logic [ACT_W-1:0]  LEN_DEF = ACT_W'(ACT_DEF);

    logic [HCNT_W-1:0] hcnt_q;
    logic              run_q;
    logic [ACT_W-1:0]  len_eff;
    logic [SUM_W-1:0]  win_lo, win_hi, hc_w;

    // Restart on sync, then count up and stick at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hcnt_q <= '0;
            run_q  <= 1'b0;
        end else if (hs_lead_i) begin
            hcnt_q <= '0;
            run_q  <= 1'b1;
        end else if (run_q && hcnt_q != HMAX) begin
            hcnt_q <= hcnt_q + 1'b1;
        end
    end

    // Resolve the window length and its bounds in a widened domain.
    always_comb begin
        len_eff = (len_i == '0) ? LEN_DEF : len_i;
        win_lo  = SUM_W'(start_i);
        win_hi  = win_lo + SUM_W'(len_eff);
        hc_w    = SUM_W'(hcnt_q);
    end

    // Enable when inside the window and not suppressed by blanking.
    always_comb begin
        cap_en_o = run_q && (hc_w >= win_lo) && (hc_w < win_hi)
                   && !(gate_i && blank_i);
    end

    assign hcount_o = hcnt_q;
    assign run_o    = run_q;
endmodule

// File: rtl/field_track.sv
// Module: field_track
// Half-line counter and field decision. The selected vertical edge clears
// the counter and fixes the field, only while syncs are inputs.
// Assumes half_i is below the horizontal counter's saturation value.
module field_track #(
    parameter int HCNT_W = 12,
    parameter int LCNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hs_lead_i,
    input  logic              vs_edge_i,
    input  logic              run_i,
    input  logic [HCNT_W-1:0] hcount_i,
    input  logic [HCNT_W-1:0] half_i,
    input  logic              fld_i,
    input  logic              sync_in_i,
    input  logic              field_ext_i,
    output logic [LCNT_W-1:0] halfline_o,
    output logic              field_o
);
    logic [LCNT_W-1:0] half_q;
    logic              field_q;
    logic              take;
    logic              mid_hit;

    // Decode the events that act on this cycle.
    always_comb begin
        take    = vs_edge_i && sync_in_i;
        mid_hit = run_i && (hcount_i == half_i);
    end

    // Count half lines; a field reset takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n)                    half_q <= '0;
        else if (take)                 half_q <= '0;
        else if (hs_lead_i || mid_hit) half_q <= half_q + 1'b1;
    end

    // Decide the field at the selected vertical edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       field_q <= 1'b0;
        else if (take)    field_q <= field_ext_i ? fld_i : (hcount_i >= half_i);
    end

    assign halfline_o = half_q;
    assign field_o    = field_q;
endmodule

// File: rtl/vid_slave_window.sv
// Module: vid_slave_window (top)
// Slave-mode input timing: polarity-normalised strobes, horizontal count,
// capture window, half-line count and field. Configuration is held static
// by the user; changing a polarity bit can itself create an edge.
module vid_slave_window
    import vts_pkg::*;
#(
    parameter int HCNT_W  = 12,
    parameter int START_W = 8,
    parameter int ACT_W   = 11,
    parameter int ACT_DEF = 720,
    parameter int LCNT_W  = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hsync_i,
    input  logic                vsync_i,
    input  logic                field_i,
    input  logic                blank_i,
    input  logic [NUM_CH-1:0]   cfg_pol_i,
    input  logic                cfg_sync_in_i,
    input  logic                cfg_vs_trail_i,
    input  logic                cfg_field_ext_i,
    input  logic                cfg_blank_gate_i,
    input  logic [START_W-1:0]  cfg_start_i,
    input  logic [ACT_W-1:0]    cfg_len_i,
    input  logic [HCNT_W-1:0]   cfg_half_i,
    output logic                cap_en_o,
    output logic [HCNT_W-1:0]   hcount_o,
    output logic [LCNT_W-1:0]   halfline_o,
    output logic                field_o
);
    logic [NUM_CH-1:0] raw;
    logic [NUM_CH-1:0] lvl;
    logic [1:0]        sync_edge;
    edge_kind_e        kinds [2];
    logic              hs_lead;
    logic              vs_edge;
    logic              run;

    // Gather strobes in channel order and choose edge directions.
    always_comb begin
        raw[CH_HS]  = hsync_i;
        raw[CH_VS]  = vsync_i;
        raw[CH_FLD] = field_i;
        raw[CH_BLK] = blank_i;
        kinds[CH_HS] = EDGE_LEAD;
        kinds[CH_VS] = cfg_vs_trail_i ? EDGE_TRAIL : EDGE_LEAD;
    end

    pol_sample #(.N(NUM_CH)) u_pol (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i (raw),
        .pol_i (cfg_pol_i),
        .lvl_o (lvl)
    );

    edge_pick #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (lvl[CH_VS:CH_HS]),
        .kind_i (kinds),
        .edge_o (sync_edge)
    );

    assign hs_lead = sync_edge[CH_HS];
    assign vs_edge = sync_edge[CH_VS];

    line_window #(
        .HCNT_W  (HCNT_W),
        .START_W (START_W),
        .ACT_W   (ACT_W),
        .ACT_DEF (ACT_DEF)
    ) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .hs_lead_i (hs_lead),
        .blank_i   (lvl[CH_BLK]),
        .gate_i    (cfg_blank_gate_i),
        .start_i   (cfg_start_i),
        .len_i     (cfg_len_i),
        .hcount_o  (hcount_o),
        .run_o     (run),
        .cap_en_o  (cap_en_o)
    );

    field_track #(
        .HCNT_W (HCNT_W),
        .LCNT_W (LCNT_W)
    ) u_field (
        .clk         (clk),
        .rst_n       (rst_n),
        .hs_lead_i   (hs_lead),
        .vs_edge_i   (vs_edge),
        .run_i       (run),
        .hcount_i    (hcount_o),
        .half_i      (cfg_half_i),
        .fld_i       (lvl[CH_FLD]),
        .sync_in_i   (cfg_sync_in_i),
        .field_ext_i (cfg_field_ext_i),
        .halfline_o  (halfline_o),
        .field_o     (field_o)
    );
endmodule

// File: rtl/vid_slave_window_chk.sv
// Module: vid_slave_window_chk
// Temporal properties of the slave timing window, bound to the top module.
module vid_slave_window_chk #(
    parameter int HCNT_W  = 12,
    parameter int START_W = 8,
    parameter int LCNT_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hs_lead,
    input logic              cap_en_o,
    input logic [HCNT_W-1:0] hcount_o,
    input logic [LCNT_W-1:0] halfline_o,
    input logic              field_o,
    input logic              cfg_sync_in_i,
    input logic [START_W-1:0] cfg_start_i
);
    localparam logic [HCNT_W-1:0] HMAX = {HCNT_W{1'b1}};

    // R2: a running count steps by one unless a sync restarts it.
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount_o != '0 && hcount_o != HMAX && !hs_lead)
            |=> hcount_o == $past(hcount_o) + HCNT_W'(1));

    // R2: the top value is held until the next sync.
    a_r2_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (hcount_o == HMAX && !hs_lead) |=> hcount_o == HMAX);

    // R3: no capture before the start count.
    a_r3_not_before_start: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en_o |-> hcount_o >= HCNT_W'(cfg_start_i));

    // R6: the half-line count only steps by one or clears.
    a_r6_half_step: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(halfline_o)
            |-> (halfline_o == '0 || halfline_o == $past(halfline_o) + LCNT_W'(1)));

    // R8: the field only moves together with a half-line clear.
    a_r8_field_with_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(field_o) |-> halfline_o == '0);

    // R9: field frozen while syncs are not inputs.
    a_r9_field_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_sync_in_i && !$past(cfg_sync_in_i)) |-> $stable(field_o));
endmodule

bind vid_slave_window vid_slave_window_chk #(
    .HCNT_W  (HCNT_W),
    .START_W (START_W),
    .LCNT_W  (LCNT_W)
) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .hs_lead       (hs_lead),
    .cap_en_o      (cap_en_o),
    .hcount_o      (hcount_o),
    .halfline_o    (halfline_o),
    .field_o       (field_o),
    .cfg_sync_in_i (cfg_sync_in_i),
    .cfg_start_i   (cfg_start_i)
);

// File: tb/vid_slave_window_tb_top.sv
`timescale 1ns/1ps
// Bench: small configuration, line-by-line sweeps with arithmetic expectations.
module vid_slave_window_tb_top;
    localparam int HW   = 8;
    localparam int SW   = 8;
    localparam int AW   = 8;
    localparam int ADEF = 20;
    localparam int LW   = 8;
    localparam int HMAX = (1 << HW) - 1;
    localparam int LINE = 40;
    localparam int HALF = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs_raw = 1'b0, vs_raw = 1'b0, fld_raw = 1'b0, blk_raw = 1'b0;
    logic [3:0] pol = 4'b0;
    logic sync_in = 1'b1, vs_trail = 1'b0, field_ext = 1'b0, gate = 1'b0;
    logic [SW-1:0] start = '0;
    logic [AW-1:0] len = 8'd4;
    logic [HW-1:0] half = HW'(HALF);
    logic cap_en, field;
    logic [HW-1:0] hcount;
    logic [LW-1:0] halfline;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    vid_slave_window #(
        .HCNT_W(HW), .START_W(SW), .ACT_W(AW), .ACT_DEF(ADEF), .LCNT_W(LW)
    ) dut_i (
        .clk(clk), .rst_n(rst_n),
        .hsync_i(hs_raw), .vsync_i(vs_raw), .field_i(fld_raw), .blank_i(blk_raw),
        .cfg_pol_i(pol), .cfg_sync_in_i(sync_in), .cfg_vs_trail_i(vs_trail),
        .cfg_field_ext_i(field_ext), .cfg_blank_gate_i(gate),
        .cfg_start_i(start), .cfg_len_i(len), .cfg_half_i(half),
        .cap_en_o(cap_en), .hcount_o(hcount), .halfline_o(halfline), .field_o(field)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_cap(input int hc, input bit blk);
        int l = (len == 0) ? ADEF : int'(len);
        if (blk && gate) return 0;
        return (hc >= int'(start) && hc < int'(start) + l) ? 1 : 0;
    endfunction

    // One line: hsync active for 3 cycles from cycle 0; optional vsync change.
    task automatic run_line(input int L, input int vs_at, input bit vs_act,
                            input bit blk_act);
        for (int j = 0; j < L; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                int hc = (j - 2 > HMAX) ? HMAX : j - 2;
                chk("R2 hcount", int'(hcount), hc);
                chk("R3/R4/R5 cap_en", int'(cap_en), exp_cap(hc, blk_act));
            end
            hs_raw = logic'(j < 3) ^ pol[0];
            if (j == vs_at) vs_raw = vs_act ^ pol[1];
            if (j == 0) blk_raw = blk_act ^ pol[3];
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        hs_raw = pol[0]; vs_raw = pol[1]; fld_raw = pol[2]; blk_raw = pol[3];
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset();
        // R10: reset values
        chk("R10 hcount", int'(hcount), 0);
        chk("R10 halfline", int'(halfline), 0);
        chk("R10 field", int'(field), 0);
        chk("R10 cap_en", int'(cap_en), 0);
        // R2: no sync yet, counter holds 0
        repeat (8) @(negedge clk);
        chk("R2 idle hcount", int'(hcount), 0);
        chk("R3 idle cap_en", int'(cap_en), 0);

        // R3/R4: sweep start and length over full lines
        for (int s = 0; s < 8; s += 3) begin
            for (int l = 0; l < 10; l += 3) begin
                start = SW'(s);
                len = AW'(l);
                run_line(LINE, -1, 1'b0, 1'b0);
            end
        end
        // R5: blank ignored when gate is off
        start = 8'd2; len = 8'd6; gate = 1'b0;
        run_line(LINE, -1, 1'b0, 1'b1);
        run_line(LINE, -1, 1'b0, 1'b0);
        // R2: saturation on a long line
        run_line(300, -1, 1'b0, 1'b0);

        // R1: every polarity combination
        for (int p = 0; p < 16; p++) begin
            pol = 4'(p);
            gate = 1'b1; field_ext = 1'b1; vs_trail = 1'b0;
            do_reset();
            run_line(LINE, -1, 1'b0, 1'b0);
            run_line(LINE, -1, 1'b0, 1'b1);   // R5 gated blank
            fld_raw = 1'b1 ^ pol[2];
            run_line(LINE, 5, 1'b1, 1'b0);
            chk("R1 R8 field from strobe", int'(field), 1);
            chk("R1 R7 halfline", int'(halfline), 1);
        end

        // R6/R7/R8: field decisions from edge position
        pol = 4'b0; gate = 1'b0; field_ext = 1'b0; vs_trail = 1'b0; sync_in = 1'b1;
        do_reset();
        run_line(LINE, -1, 1'b0, 1'b0);
        run_line(LINE, 5, 1'b1, 1'b0);
        chk("R8 early edge field", int'(field), 0);
        chk("R7 leading clear", int'(halfline), 1);
        run_line(LINE, -1, 1'b0, 1'b0);
        chk("R6 two per line", int'(halfline), 3);
        run_line(LINE, 5, 1'b0, 1'b0);
        chk("R7 trailing ignored", int'(halfline), 5);
        run_line(LINE, 30, 1'b1, 1'b0);
        chk("R8 late edge field", int'(field), 1);
        chk("R7 late clear", int'(halfline), 0);
        vs_trail = 1'b1;
        run_line(LINE, 5, 1'b0, 1'b0);
        chk("R7 trailing edge field", int'(field), 0);
        chk("R7 trailing clear", int'(halfline), 1);
        run_line(LINE, 30, 1'b1, 1'b0);
        chk("R7 leading ignored", int'(halfline), 3);

        // R9: syncs not inputs
        sync_in = 1'b0;
        run_line(LINE, 5, 1'b0, 1'b0);
        run_line(LINE, 30, 1'b1, 1'b0);
        run_line(LINE, 30, 1'b0, 1'b0);
        chk("R9 field held", int'(field), 0);
        chk("R9 no clear", int'(halfline), 9);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule